// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A packed 8-bit mode word sets the frame: 7, 8 or 9 data bits, one or two stop bits, an optional parity bit of odd or even sense, a clock choice and a sleep filter for 9-bit traffic. The bit clock is derived in two stages. A source clock is taken either from the core clock through a 1/2/4/8 prescaler or from the rising edges of an external clock pin. That clock is divided by (n+1), where n is the bit-rate register, and the result is a 16x oversampling tick. Each bit on the line therefore lasts 16 ticks.

The transmitter accepts a character on a valid/ready handshake and shifts it out LSB first. The receiver detects a start bit on a falling edge and confirms it at tick 8 of the bit. It then samples each later bit at its middle and presents the character together with parity-error and framing-error flags. The character stays on the outputs until it is acknowledged. An optional flow-control pair can be enabled. The active-low `cts_n` input then holds back new frames, and the active-low `rts_n` output signals that the receive buffer is empty.

Transmitter states are `T_IDLE`, `T_START`, `T_DATA`, `T_PAR` and `T_STOP`, with the following transitions:
- `T_IDLE` to `T_START` on accept.
- `T_START` to `T_DATA` after 16 ticks.
- `T_DATA` to `T_PAR` or `T_STOP` after the last data bit.
- `T_PAR` to `T_STOP`.
- `T_STOP` to `T_IDLE` after the last stop bit.

Receiver states are `R_IDLE`, `R_START`, `R_DATA`, `R_PAR` and `R_STOP`, with the following transitions:
- `R_IDLE` to `R_START` on a falling edge.
- `R_START` to `R_DATA` if the line is low at tick 8, or back to `R_IDLE` if it is high.
- `R_DATA` to `R_PAR` or `R_STOP` after the last data bit.
- `R_PAR` to `R_STOP`.
- `R_STOP` to `R_IDLE` at the middle of the last stop bit, where the character is delivered.

Both machines are forced to their idle state while the mode word selects no asynchronous format.

Top module: `sercom_async`

## Requirements
- R1: `mode_reg[2:0]` selects the data length: 100 gives 7 bits, 101 gives 8 bits and 110 gives 9 bits. Any other value disables the block. In that case `tx_ready` stays 0 and no received frame sets `rx_valid`.
- R2: One bit on the line lasts P = S*(n+1)*16 core cycles, where n is `brg_div`. With `mode_reg[3]`=0, S is 2^`clk_div_sel`. With `mode_reg[3]`=1, S is the number of core cycles between rising edges of `ext_clk`.
- R3: The line idles at 1. A frame is a 0 start bit, then the data bits LSB first, then the optional parity bit, then the stop bits at 1. The start bit appears on `txd` in the cycle after `tx_valid` and `tx_ready` are both high.
- R4: `mode_reg[4]`=0 selects one stop bit and `mode_reg[4]`=1 selects two stop bits, for both transmit and receive.
- R5: `mode_reg[6]`=1 adds a parity bit. With `mode_reg[5]`=1 the count of ones across the data and parity bits is even. With `mode_reg[5]`=0 that count is odd.
- R6: A received character appears right-justified on `rx_data` with `rx_valid`=1. `rx_valid` stays 1 until `rx_ack` is pulsed.
- R7: `rx_perr` is 1 for a delivered character whose parity check fails, and 0 otherwise.
- R8: `rx_ferr` is 1 for a delivered character when any of its stop bits is sampled as 0.
- R9: With `flow_en`=1 and `cts_n`=1, `tx_ready` is 0 and no new frame starts. A frame already under way completes unchanged. With `flow_en`=0, `cts_n` has no effect.
- R10: With `flow_en`=1, `rts_n` is 0 while `rx_valid` is 0 and 1 while `rx_valid` is 1. With `flow_en`=0, `rts_n` stays at 1.
- R11: With `mode_reg[7]`=1 in 9-bit mode, a frame whose ninth data bit (`rx_data[8]`) is 0 is dropped, and `rx_valid` stays 0. A frame whose ninth data bit is 1 is delivered.
- R12: A low pulse on `rxd` that has ended before tick 8 of the bit is rejected as a false start, and no character is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 8 | Frame format, clock choice and sleep |
| clk_div_sel | input | 2 | Internal prescaler select, divides by 2^value |
| flow_en | input | 1 | Enables the CTS/RTS flow-control pair |
| brg_div | input | 8 | Bit-rate divider value n, divides by n+1 |
| ext_clk | input | 1 | External source clock, rising edges counted |
| tx_data | input | 9 | Character to send, right-justified |
| tx_valid | input | 1 | A character is offered |
| tx_ready | output | 1 | The transmitter takes a character this cycle |
| rx_data | output | 9 | Received character, right-justified |
| rx_valid | output | 1 | `rx_data` holds an unread character |
| rx_ack | input | 1 | Read strobe that clears `rx_valid` |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Active-low clear-to-send |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
`txd` drops to the start bit one clock after an accepted handshake. After that, every bit boundary lies 16 ticks after the previous one, except that the start bit may be up to one tick short. The bench therefore samples the transmitted frame at mid-bit, at P/2 plus k*P cycles after the accept. The tolerance is a full tick, and the start-bit measurements for rate checks use a window of one tick. A received character is loaded at the middle of the final stop bit, a few cycles after the synchronizer and tick delay. The bench drives each stop bit for a full period P and checks `rx_valid`, `rx_data` and the flags only after the frame has ended. `rts_n` follows `rx_valid` in the same cycle, and the bench checks it at the falling edge after the load and again after the acknowledge.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        T_IDLE,
        T_START,
        T_DATA,
        T_PAR,
        T_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        R_IDLE,
        R_START,
        R_DATA,
        R_PAR,
        R_STOP
    } rx_state_t;

    typedef struct packed {
        logic       enable;
        logic [3:0] nbits;
        logic       use_ext;
        logic       two_stop;
        logic       par_even;
        logic       par_en;
        logic       sleep;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_mode(input logic [7:0] m);
        frame_cfg_t c;
        c.enable   = 1'b1;
        c.nbits    = 4'd8;
        case (m[2:0])
            3'b100:  c.nbits = 4'd7;
            3'b101:  c.nbits = 4'd8;
            3'b110:  c.nbits = 4'd9;
            default: c.enable = 1'b0;
        endcase
        c.use_ext  = m[3];
        c.two_stop = m[4];
        c.par_even = m[5];
        c.par_en   = m[6];
        c.sleep    = m[7];
        return c;
    endfunction

endpackage

// File: rtl/sercom_baud.sv
module sercom_baud #(
    parameter int DIV_W       = 8,
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_ext,
    input  logic             ext_clk,
    input  logic [1:0]       clk_div_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick16
);

    logic [SYNC_STAGES:0] ext_q;
    logic [PRE_W-1:0]     pre_cnt;
    logic [PRE_W-1:0]     pre_mask;
    logic [DIV_W-1:0]     div_cnt;
    logic                 src_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q   <= '0;
            pre_cnt <= '0;
        end else begin
            ext_q   <= {ext_q[SYNC_STAGES-1:0], ext_clk};
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_comb begin
        pre_mask = PRE_W'((1 << clk_div_sel) - 1);
        if (use_ext)
            src_tick = ext_q[SYNC_STAGES-1] & ~ext_q[SYNC_STAGES];
        else
            src_tick = ((pre_cnt & pre_mask) == pre_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick16  <= 1'b0;
        end else begin
            tick16 <= 1'b0;
            if (src_tick) begin
                if (div_cnt >= div_n) begin
                    div_cnt <= '0;
                    tick16  <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                enable,
    input  logic [3:0]          nbits,
    input  logic                two_stop,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                cts_block,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                txd
);

    tx_state_t           state;
    logic [3:0]          sub;
    logic [3:0]          bitn;
    logic [MAX_BITS-1:0] shreg;
    logic                par_bit;
    logic                stopn;
    logic                bit_end;
    logic [MAX_BITS-1:0] dmask;

    assign dmask   = {MAX_BITS{1'b1}} >> (4'(MAX_BITS) - nbits);
    assign bit_end = tick16 && (sub == 4'd15);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= T_IDLE;
            sub     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            stopn   <= 1'b0;
        end else if (!enable) begin
            state <= T_IDLE;
        end else begin
            if (state != T_IDLE && tick16)
                sub <= sub + 4'd1;
            unique case (state)
                T_IDLE: begin
                    if (tx_valid && tx_ready) begin
                        shreg   <= tx_data & dmask;
                        par_bit <= (^(tx_data & dmask)) ^ ~par_even;
                        sub     <= '0;
                        state   <= T_START;
                    end
                end
                T_START: begin
                    if (bit_end) begin
                        bitn  <= '0;
                        state <= T_DATA;
                    end
                end
                T_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (bitn == nbits - 4'd1) begin
                            stopn <= 1'b0;
                            state <= par_en ? T_PAR : T_STOP;
                        end else begin
                            bitn <= bitn + 4'd1;
                        end
                    end
                end
                T_PAR: begin
                    if (bit_end) begin
                        stopn <= 1'b0;
                        state <= T_STOP;
                    end
                end
                T_STOP: begin
                    if (bit_end) begin
                        if (stopn == two_stop)
                            state <= T_IDLE;
                        else
                            stopn <= 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        tx_ready = 1'b0;
        txd      = 1'b1;
        unique case (state)
            T_IDLE:  tx_ready = enable && !cts_block;
            T_START: txd = 1'b0;
            T_DATA:  txd = shreg[0];
            T_PAR:   txd = par_bit;
            T_STOP:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                enable,
    input  logic [3:0]          nbits,
    input  logic                two_stop,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                sleep,
    input  logic                rxd_s,
    input  logic                rx_ack,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_perr,
    output logic                rx_ferr
);

    rx_state_t           state;
    logic [3:0]          sub;
    logic [3:0]          bitn;
    logic [MAX_BITS-1:0] shreg;
    logic                par_acc;
    logic                ferr_acc;
    logic                stopn;
    logic                prev;
    logic                mid;
    logic                done;
    logic                discard;
    logic [MAX_BITS-1:0] aligned;

    assign mid     = (sub == 4'd15);
    assign done    = enable && tick16 && (state == R_STOP) && mid && (stopn == two_stop);
    assign aligned = shreg >> (4'(MAX_BITS) - nbits);
    assign discard = sleep && (nbits == 4'(MAX_BITS)) && !shreg[MAX_BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= R_IDLE;
            sub      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            ferr_acc <= 1'b0;
            stopn    <= 1'b0;
            prev     <= 1'b1;
        end else if (!enable) begin
            state <= R_IDLE;
            prev  <= 1'b1;
        end else if (tick16) begin
            prev <= rxd_s;
            sub  <= sub + 4'd1;
            unique case (state)
                R_IDLE: begin
                    sub <= '0;
                    if (prev && !rxd_s)
                        state <= R_START;
                end
                R_START: begin
                    if (sub == 4'd7) begin
                        sub      <= '0;
                        bitn     <= '0;
                        par_acc  <= 1'b0;
                        ferr_acc <= 1'b0;
                        state    <= rxd_s ? R_IDLE : R_DATA;
                    end
                end
                R_DATA: begin
                    if (mid) begin
                        shreg   <= {rxd_s, shreg[MAX_BITS-1:1]};
                        par_acc <= par_acc ^ rxd_s;
                        if (bitn == nbits - 4'd1) begin
                            stopn <= 1'b0;
                            state <= par_en ? R_PAR : R_STOP;
                        end else begin
                            bitn <= bitn + 4'd1;
                        end
                    end
                end
                R_PAR: begin
                    if (mid) begin
                        par_acc <= par_acc ^ rxd_s;
                        stopn   <= 1'b0;
                        state   <= R_STOP;
                    end
                end
                R_STOP: begin
                    if (mid) begin
                        if (!rxd_s)
                            ferr_acc <= 1'b1;
                        if (stopn == two_stop)
                            state <= R_IDLE;
                        else
                            stopn <= 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
        end else if (done && !discard) begin
            rx_data  <= aligned;
            rx_valid <= 1'b1;
            rx_perr  <= par_en && (par_acc ^ ~par_even);
            rx_ferr  <= ferr_acc || !rxd_s;
        end else if (rx_ack) begin
            rx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sercom_async.sv
module sercom_async
    import sercom_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          mode_reg,
    input  logic [1:0]          clk_div_sel,
    input  logic                flow_en,
    input  logic [DIV_W-1:0]    brg_div,
    input  logic                ext_clk,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    input  logic                rx_ack,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                txd,
    input  logic                rxd,
    input  logic                cts_n,
    output logic                rts_n
);

    frame_cfg_t             cfg;
    logic                   tick16;
    logic [SYNC_STAGES-1:0] rx_sync;

    assign cfg = decode_mode(mode_reg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_sync <= '1;
        else
            rx_sync <= {rx_sync[SYNC_STAGES-2:0], rxd};
    end

    sercom_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_baud (
        .clk         (clk),
        .rst_n       (rst_n),
        .use_ext     (cfg.use_ext),
        .ext_clk     (ext_clk),
        .clk_div_sel (clk_div_sel),
        .div_n       (brg_div),
        .tick16      (tick16)
    );

    sercom_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .enable    (cfg.enable),
        .nbits     (cfg.nbits),
        .two_stop  (cfg.two_stop),
        .par_en    (cfg.par_en),
        .par_even  (cfg.par_even),
        .cts_block (flow_en && cts_n),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .txd       (txd)
    );

    sercom_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .enable   (cfg.enable),
        .nbits    (cfg.nbits),
        .two_stop (cfg.two_stop),
        .par_en   (cfg.par_en),
        .par_even (cfg.par_even),
        .sleep    (cfg.sleep),
        .rxd_s    (rx_sync[SYNC_STAGES-1]),
        .rx_ack   (rx_ack),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr)
    );

    assign rts_n = flow_en ? rx_valid : 1'b1;

endmodule

// File: rtl/sercom_async_chk.sv
module sercom_async_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mode_reg,
    input logic       flow_en,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       rx_ack,
    input logic       txd,
    input logic       cts_n,
    input logic       rts_n
);

    logic mode_ok;
    assign mode_ok = (mode_reg[2:0] == 3'b100) || (mode_reg[2:0] == 3'b101)
                  || (mode_reg[2:0] == 3'b110);

    p_disabled_no_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |-> !tx_ready);

    p_idle_line_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    p_start_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && mode_ok) |=> !txd);

    p_valid_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> rx_valid);

    p_cts_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && cts_n) |-> !tx_ready);

    p_rts_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |-> rts_n);

endmodule

bind sercom_async sercom_async_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_reg (mode_reg),
    .flow_en  (flow_en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ack   (rx_ack),
    .txd      (txd),
    .cts_n    (cts_n),
    .rts_n    (rts_n)
);

// File: tb/sercom_async_tb.sv
module sercom_async_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_reg = 8'h05;
    logic [1:0] clk_div_sel = 2'd0;
    logic       flow_en = 1'b0;
    logic [7:0] brg_div = 8'd1;
    logic       ext_clk = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       rx_ack = 1'b0;
    logic       rx_perr;
    logic       rx_ferr;
    logic       txd;
    logic       rxd = 1'b1;
    logic       cts_n = 1'b1;
    logic       rts_n;

    int  errors = 0;
    int  checks = 0;
    int  P = 32;
    int  nb = 8;
    bit  pe = 0, ev = 0, ts = 0;
    bit  ext_run = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    sercom_async u_dut (
        .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .clk_div_sel(clk_div_sel),
        .flow_en(flow_en), .brg_div(brg_div), .ext_clk(ext_clk),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .txd(txd), .rxd(rxd),
        .cts_n(cts_n), .rts_n(rts_n)
    );

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_fmt(input int nbits, input bit par, input bit even, input bit two,
                           input bit slp, input bit ext);
        logic [2:0] lc;
        nb = nbits; pe = par; ev = even; ts = two;
        lc = (nbits == 7) ? 3'b100 : (nbits == 9) ? 3'b110 : 3'b101;
        mode_reg = {slp, par, even, two, ext, lc};
        repeat (2) @(negedge clk);
    endtask

    task automatic make_frame(input int d, output bit fr[16], output int cnt);
        int ones = 0;
        cnt = 0;
        foreach (fr[i]) fr[i] = 1'b1;
        fr[cnt++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            fr[cnt++] = d[i];
            ones += d[i];
        end
        if (pe) fr[cnt++] = ev ? ones[0] : ~ones[0];
        fr[cnt++] = 1'b1;
        if (ts) fr[cnt++] = 1'b1;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!tx_ready && n < 40 * P) begin
            @(negedge clk);
            n++;
        end
        chk(tx_ready, tag, int'(tx_ready), 1);
    endtask

    task automatic tx_frame(input int d, input bit drop_cts_mid, input string tag);
        bit fr[16];
        int cnt;
        int bad = 0;
        make_frame(d, fr, cnt);
        wait_ready(tag);
        tx_data = 9'(d);
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (P / 2) @(negedge clk);
        if (txd != fr[0]) bad++;
        for (int k = 1; k < cnt; k++) begin
            if (drop_cts_mid && k == 2) cts_n = 1'b1;
            repeat (P) @(negedge clk);
            if (txd != fr[k]) bad = bad + 1 + k * 16;
        end
        chk(bad == 0, tag, bad, 0);
        repeat (P / 2 + P / 16 + 2) @(negedge clk);
    endtask

    task automatic drive_bits(input bit fr[16], input int cnt);
        for (int k = 0; k < cnt; k++) begin
            rxd = fr[k];
            repeat (P) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack_rx;
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_frame(input int d, input bit flip_par, input bit zero_stop,
                            input int ep, input int ef, input string tag);
        bit fr[16];
        int cnt;
        int mask = (1 << nb) - 1;
        make_frame(d, fr, cnt);
        if (flip_par) fr[1 + nb] = ~fr[1 + nb];
        if (zero_stop) fr[cnt - 1] = 1'b0;
        drive_bits(fr, cnt);
        chk(rx_valid == 1'b1, {tag, " valid"}, int'(rx_valid), 1);
        chk(int'(rx_data) == (d & mask), {tag, " data"}, int'(rx_data), d & mask);
        chk(int'(rx_perr) == ep && int'(rx_ferr) == ef, {tag, " flags"},
            int'({rx_perr, rx_ferr}), ep * 2 + ef);
        ack_rx();
    endtask

    task automatic measure_rate(input int exp_p, input string tag);
        int len = 0;
        int t = exp_p / 16;
        P = exp_p;
        wait_ready(tag);
        tx_data = 9'h001;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (txd == 1'b0 && len < 4 * exp_p) begin
            len++;
            @(negedge clk);
        end
        chk(len >= exp_p - t - 1 && len <= exp_p + 1, tag, len, exp_p);
        repeat (11 * exp_p) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(txd == 1'b1 && tx_ready == 1'b1, "R3 reset idle line", int'({txd, tx_ready}), 3);
        chk(rx_valid == 1'b0, "R6 reset no char", int'(rx_valid), 0);
        chk(rts_n == 1'b1, "R10 reset rts released", int'(rts_n), 1);
    endtask

    task automatic t_tx_formats;
        set_fmt(8, 0, 0, 0, 0, 0);
        tx_frame(9'h0A5, 0, "R3 tx 8N1");
        tx_frame(9'h03C, 0, "R3 tx 8N1 second");
        set_fmt(7, 1, 1, 1, 0, 0);
        tx_frame(9'h06B, 0, "R4 R5 tx 7E2");
        set_fmt(9, 1, 0, 0, 0, 0);
        tx_frame(9'h1C3, 0, "R5 tx 9O1");
        tx_frame(9'h000, 0, "R5 tx 9O1 zero");
    endtask

    task automatic t_rx_formats;
        set_fmt(8, 0, 0, 0, 0, 0);
        rx_frame(8'h5A, 0, 0, 0, 0, "R6 rx 8N1");
        set_fmt(7, 1, 0, 1, 0, 0);
        rx_frame(7'h41, 0, 0, 0, 0, "R4 rx 7O2");
        set_fmt(8, 1, 1, 0, 0, 0);
        rx_frame(8'hC7, 0, 0, 0, 0, "R7 rx good parity");
        rx_frame(8'hC7, 1, 0, 1, 0, "R7 rx parity error");
        set_fmt(8, 0, 0, 0, 0, 0);
        rx_frame(8'h33, 0, 1, 0, 1, "R8 rx framing error");
        repeat (2 * P) @(negedge clk);
        rx_frame(8'h81, 0, 0, 0, 0, "R8 rx recovery");
    endtask

    task automatic t_glitch;
        rxd = 1'b0;
        repeat (P / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * P) @(negedge clk);
        chk(rx_valid == 1'b0, "R12 short low pulse rejected", int'(rx_valid), 0);
    endtask

    task automatic t_sleep;
        bit fr[16];
        int cnt;
        set_fmt(9, 0, 0, 0, 1, 0);
        make_frame(9'h055, fr, cnt);
        drive_bits(fr, cnt);
        repeat (P) @(negedge clk);
        chk(rx_valid == 1'b0, "R11 sleep drops ninth bit 0", int'(rx_valid), 0);
        rx_frame(9'h1A5, 0, 0, 0, 0, "R11 sleep keeps ninth bit 1");
        set_fmt(9, 0, 0, 0, 0, 0);
        rx_frame(9'h055, 0, 0, 0, 0, "R11 no sleep keeps ninth bit 0");
    endtask

    task automatic t_flow;
        int hi = 1;
        set_fmt(8, 0, 0, 0, 0, 0);
        flow_en = 1'b1;
        cts_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R9 cts high holds ready", int'(tx_ready), 0);
        tx_data = 9'h0F0;
        tx_valid = 1'b1;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (txd != 1'b1) hi = 0;
        end
        tx_valid = 1'b0;
        chk(hi == 1, "R9 no frame while cts high", hi, 1);
        cts_n = 1'b0;
        @(negedge clk);
        tx_frame(9'h0E1, 1, "R9 frame completes after cts rises");
        chk(tx_ready == 1'b0, "R9 ready low after frame", int'(tx_ready), 0);
        chk(rts_n == 1'b0, "R10 rts low when empty", int'(rts_n), 0);
        cts_n = 1'b0;
        begin
            bit fr[16];
            int cnt;
            make_frame(8'h66, fr, cnt);
            drive_bits(fr, cnt);
        end
        chk(rts_n == 1'b1, "R10 rts high when full", int'(rts_n), 1);
        ack_rx();
        chk(rts_n == 1'b0, "R10 rts low after read", int'(rts_n), 0);
        flow_en = 1'b0;
        cts_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1 && rts_n == 1'b1, "R9 R10 flow off ignores cts",
            int'({tx_ready, rts_n}), 3);
    endtask

    task automatic t_disabled;
        bit fr[16];
        int cnt;
        set_fmt(8, 0, 0, 0, 0, 0);
        make_frame(8'h99, fr, cnt);
        mode_reg = 8'h00;
        repeat (2) @(negedge clk);
        chk(tx_ready == 1'b0, "R1 invalid mode no ready", int'(tx_ready), 0);
        drive_bits(fr, cnt);
        chk(rx_valid == 1'b0, "R1 invalid mode no receive", int'(rx_valid), 0);
        mode_reg = 8'h07;
        repeat (2) @(negedge clk);
        chk(tx_ready == 1'b0, "R1 code 111 no ready", int'(tx_ready), 0);
    endtask

    task automatic t_rates;
        set_fmt(8, 0, 0, 0, 0, 0);
        brg_div = 8'd3;
        clk_div_sel = 2'd0;
        measure_rate(64, "R2 rate n=3 div1");
        brg_div = 8'd0;
        clk_div_sel = 2'd2;
        measure_rate(64, "R2 rate n=0 div4");
        clk_div_sel = 2'd1;
        brg_div = 8'd2;
        measure_rate(96, "R2 rate n=2 div2");
        ext_run = 1;
        brg_div = 8'd0;
        set_fmt(8, 0, 0, 0, 0, 1);
        measure_rate(64, "R2 rate external clock");
        P = 64;
        rx_frame(8'hA3, 0, 0, 0, 0, "R2 rx on external clock");
        ext_run = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_tx_formats();
        t_rx_formats();
        t_glitch();
        t_sleep();
        t_flow();
        t_disabled();
        t_rates();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule